// File: doc/BRIEF.md
# Peripheral Power State Sequencer

This block stands between a central power controller and a set of peripheral submodules, one sequencer channel per submodule. Each channel takes a two-bit mode request and moves its submodule among three settled conditions: running, idle (clock stopped, register contents kept), and synchronized reset (reset applied while the clock still runs, then clock stopped). It drives the clock-gate enable, the submodule reset and the register-access enable. It returns a one-cycle acknowledge when the requested condition has settled.

Leaving idle needs no software action. Leaving synchronized reset restarts the clock with reset still applied, so that reset is released synchronously. It also raises a needs-reinit flag, and data transfer stays blocked until software reports that it has reprogrammed the submodule. Register accesses made while a submodule cannot accept them read as zero and raise an access-error pulse.

The channels are generated from a parameter, and each one is sequenced independently. Clock-gating cells and the submodule's registers lie outside the block and are represented only by the enables.

Top module: `pwr_state_seq`

## Requirements
- R1: In idle (status 1), clk_en=0, acc_en=0 and periph_rst=0 for that channel.
- R2: A register value written before idle entry reads back unchanged after the return to active, with no reinitialization.
- R3: On a synchronized-reset request (code 2'b10) from active or idle, periph_rst rises while clk_en=1. Reset is held with the clock running for RST_HOLD cycles (at least 4). After that, clk_en drops while periph_rst stays 1 (status 3).
- R4: On an active request (2'b00) in the gated-reset state, clk_en returns with periph_rst still 1 for CLK_PRE cycles. periph_rst then falls. After this exit, the submodule's registers hold their default values.
- R5: needs_reinit becomes 1 in the cycle after periph_rst is first seen high. It clears only when reinit_done is sampled high while the channel is active. xfer_en is 1 only when the channel is active and needs_reinit=0.
- R6: A register access strobe (acc_req) while acc_en=0 returns rd_data_out=0 and gives a one-cycle acc_err in the following cycle. While acc_en=1, rd_data_out equals rd_data_in and acc_err stays 0.
- R7: The mode codes are 2'b00 active, 2'b01 idle and 2'b10 synchronized reset. Code 2'b11 is ignored. A request for the current state is ignored. An idle request in the reset states is ignored. Requests made during the timed phases take effect only after the settled state is reached. mode_ack is high for exactly one cycle: the first cycle in which status shows a newly reached settled state (0, 1 or 3).
- R8: Each channel's outputs depend only on that channel's inputs.
- R9: The status codes are 0 active, 1 idle, 2 reset with the clock running (entry), 3 reset with the clock gated, and 4 reset with the clock running (exit).
- R10: After rst_n is released, every channel reports status 0, clk_en=1, periph_rst=0, acc_en=1, needs_reinit=0 and mode_ack=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2*N_SUB | Requested mode per channel |
| mode_ack | output | N_SUB | Transition-complete pulse per channel |
| status | output | 3*N_SUB | Sequencer state code per channel |
| clk_en | output | N_SUB | Clock-gate enable per submodule |
| periph_rst | output | N_SUB | Active-high submodule reset |
| acc_en | output | N_SUB | Register access permitted |
| reinit_done | input | N_SUB | Software finished reinitializing |
| needs_reinit | output | N_SUB | Reinitialization pending after reset |
| xfer_en | output | N_SUB | Data transfer permitted |
| acc_req | input | N_SUB | Register access strobe |
| rd_data_in | input | DW*N_SUB | Read data from submodule registers |
| rd_data_out | output | DW*N_SUB | Read data returned to requester |
| acc_err | output | N_SUB | Blocked-access error pulse |

## Verification
The embedded assertions check on every cycle the ordering rules between the reset line and the clock enable: reset rises only with the clock running, the clock drops only under an already-held reset, and reset falls only after the clock has run. They also check that an acknowledge always coincides with a state change, that transfer is never enabled while the clock is stopped or reset is applied, and that every access error follows a cycle in which access was disabled. Other behaviours need the bench's scenarios: the exact phase lengths, the deferral and ignoring of requests, retention of a written register across idle, the return to default values after synchronized reset, and the independence of the channels.

// File: rtl/pss_pkg.sv
package pss_pkg;
   typedef enum logic [2:0] {
      PSS_ACTIVE    = 3'd0,
      PSS_IDLE      = 3'd1,
      PSS_RST_ON    = 3'd2,
      PSS_RST_GATED = 3'd3,
      PSS_RST_OFF   = 3'd4
   } pss_state_e;

   localparam logic [1:0] MODE_ACTIVE = 2'b00;
   localparam logic [1:0] MODE_IDLE   = 2'b01;
   localparam logic [1:0] MODE_SRST   = 2'b10;

   function automatic logic pss_settled(input pss_state_e s);
      return (s == PSS_ACTIVE) || (s == PSS_IDLE) || (s == PSS_RST_GATED);
   endfunction
endpackage

// File: rtl/pss_chan_fsm.sv
module pss_chan_fsm
   import pss_pkg::*;
#(
   parameter int RST_HOLD = 4,
   parameter int CLK_PRE  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_req,
   output logic       clk_en_o,
   output logic       periph_rst_o,
   output logic       acc_en_o,
   output logic       ack_o,
   output logic [2:0] status_o
);
   localparam int MAXC = (RST_HOLD > CLK_PRE) ? RST_HOLD : CLK_PRE;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] HOLD_LAST = CW'(RST_HOLD - 1);
   localparam logic [CW-1:0] PRE_LAST  = CW'(CLK_PRE - 1);

   pss_state_e     st_q, nxt;
   logic [CW-1:0]  cnt_q;
   logic           ack_q;

   always_comb begin
      nxt = st_q;
      unique case (st_q)
         PSS_ACTIVE:    if (mode_req == MODE_IDLE) nxt = PSS_IDLE;
                        else if (mode_req == MODE_SRST) nxt = PSS_RST_ON;
         PSS_IDLE:      if (mode_req == MODE_ACTIVE) nxt = PSS_ACTIVE;
                        else if (mode_req == MODE_SRST) nxt = PSS_RST_ON;
         PSS_RST_ON:    if (cnt_q == HOLD_LAST) nxt = PSS_RST_GATED;
         PSS_RST_GATED: if (mode_req == MODE_ACTIVE) nxt = PSS_RST_OFF;
         PSS_RST_OFF:   if (cnt_q == PRE_LAST) nxt = PSS_ACTIVE;
         default:       nxt = PSS_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PSS_ACTIVE;
         cnt_q <= '0;
         ack_q <= 1'b0;
      end else begin
         st_q  <= nxt;
         ack_q <= (nxt != st_q) && pss_settled(nxt);
         if (nxt != st_q)
            cnt_q <= '0;
         else if ((st_q == PSS_RST_ON) || (st_q == PSS_RST_OFF))
            cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      clk_en_o     = (st_q == PSS_ACTIVE) || (st_q == PSS_RST_ON) || (st_q == PSS_RST_OFF);
      periph_rst_o = (st_q == PSS_RST_ON) || (st_q == PSS_RST_GATED) || (st_q == PSS_RST_OFF);
      acc_en_o     = (st_q == PSS_ACTIVE);
      ack_o        = ack_q;
      status_o     = st_q;
   end

   // R3
   rst_rise_clocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(periph_rst_o) |-> clk_en_o);
   // R3
   gate_under_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_rst_o && !clk_en_o) |-> $past(periph_rst_o));
   // R4
   rst_release_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(periph_rst_o) |-> (clk_en_o && $past(clk_en_o)));
   // R7
   ack_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (status_o != $past(status_o)));
endmodule

// File: rtl/pss_reinit_track.sv
module pss_reinit_track (
   input  logic clk,
   input  logic rst_n,
   input  logic periph_rst_i,
   input  logic clk_en_i,
   input  logic acc_en_i,
   input  logic reinit_done_i,
   output logic needs_reinit_o,
   output logic xfer_en_o
);
   logic nr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        nr_q <= 1'b0;
      else if (periph_rst_i)             nr_q <= 1'b1;
      else if (acc_en_i && reinit_done_i) nr_q <= 1'b0;
   end

   assign needs_reinit_o = nr_q;
   assign xfer_en_o      = acc_en_i && !nr_q;

   // R5
   reinit_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(needs_reinit_o) |-> $past(periph_rst_i));
   // R5
   xfer_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_en_o |-> (clk_en_i && !periph_rst_i));
endmodule

// File: rtl/pss_access_gate.sv
module pss_access_gate #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_en_i,
   input  logic          acc_req_i,
   input  logic [DW-1:0] rd_in,
   output logic [DW-1:0] rd_out,
   output logic          acc_err_o
);
   logic err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= acc_req_i && !acc_en_i;
   end

   assign rd_out    = acc_en_i ? rd_in : '0;
   assign acc_err_o = err_q;

   // R6
   err_from_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err_o |-> !$past(acc_en_i));
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq #(
   parameter int N_SUB    = 3,
   parameter int DW       = 16,
   parameter int RST_HOLD = 4,
   parameter int CLK_PRE  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*N_SUB-1:0]  mode_req,
   output logic [N_SUB-1:0]    mode_ack,
   output logic [3*N_SUB-1:0]  status,
   output logic [N_SUB-1:0]    clk_en,
   output logic [N_SUB-1:0]    periph_rst,
   output logic [N_SUB-1:0]    acc_en,
   input  logic [N_SUB-1:0]    reinit_done,
   output logic [N_SUB-1:0]    needs_reinit,
   output logic [N_SUB-1:0]    xfer_en,
   input  logic [N_SUB-1:0]    acc_req,
   input  logic [DW*N_SUB-1:0] rd_data_in,
   output logic [DW*N_SUB-1:0] rd_data_out,
   output logic [N_SUB-1:0]    acc_err
);
   if (N_SUB < 1)    begin : g_bad_n    $error("N_SUB must be at least 1");    end
   if (DW < 1)       begin : g_bad_dw   $error("DW must be at least 1");       end
   if (RST_HOLD < 4) begin : g_bad_hold $error("RST_HOLD must be at least 4"); end
   if (CLK_PRE < 1)  begin : g_bad_pre  $error("CLK_PRE must be at least 1");  end

   for (genvar i = 0; i < N_SUB; i++) begin : g_chan
      logic ce, pr, ae;

      pss_chan_fsm #(.RST_HOLD(RST_HOLD), .CLK_PRE(CLK_PRE)) u_fsm (
         .clk          (clk),
         .rst_n        (rst_n),
         .mode_req     (mode_req[2*i +: 2]),
         .clk_en_o     (ce),
         .periph_rst_o (pr),
         .acc_en_o     (ae),
         .ack_o        (mode_ack[i]),
         .status_o     (status[3*i +: 3])
      );

      pss_reinit_track u_reinit (
         .clk            (clk),
         .rst_n          (rst_n),
         .periph_rst_i   (pr),
         .clk_en_i       (ce),
         .acc_en_i       (ae),
         .reinit_done_i  (reinit_done[i]),
         .needs_reinit_o (needs_reinit[i]),
         .xfer_en_o      (xfer_en[i])
      );

      pss_access_gate #(.DW(DW)) u_gate (
         .clk       (clk),
         .rst_n     (rst_n),
         .acc_en_i  (ae),
         .acc_req_i (acc_req[i]),
         .rd_in     (rd_data_in[DW*i +: DW]),
         .rd_out    (rd_data_out[DW*i +: DW]),
         .acc_err_o (acc_err[i])
      );

      assign clk_en[i]     = ce;
      assign periph_rst[i] = pr;
      assign acc_en[i]     = ae;
   end
endmodule

// File: tb/tb_pwr_state_seq.sv
module tb_pwr_state_seq;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 3;
   localparam int DW   = 16;
   localparam int HOLD = 4;
   localparam int PRE  = 2;
   localparam logic [DW-1:0] DEF = 16'h0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2*N-1:0] mode_req = '0;
   logic [N-1:0] mode_ack, clk_en, periph_rst, acc_en, needs_reinit, xfer_en, acc_err;
   logic [3*N-1:0] status;
   logic [N-1:0] reinit_done = '0, acc_req = '0, wr = '0;
   logic [DW*N-1:0] rd_data_in, rd_data_out;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] preg [N];

   int vectors = 0, fails = 0;
   bit chk_on = 1'b0;

   int m_st[N], m_cnt[N];
   bit m_ack[N], m_nr[N], m_err[N];

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_state_seq #(.N_SUB(N), .DW(DW), .RST_HOLD(HOLD), .CLK_PRE(PRE)) dut (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_ack(mode_ack),
      .status(status), .clk_en(clk_en), .periph_rst(periph_rst), .acc_en(acc_en),
      .reinit_done(reinit_done), .needs_reinit(needs_reinit), .xfer_en(xfer_en),
      .acc_req(acc_req), .rd_data_in(rd_data_in), .rd_data_out(rd_data_out),
      .acc_err(acc_err)
   );

   // peripheral register model: reset needs a running clock
   always @(posedge clk) begin
      for (int c = 0; c < N; c++) begin
         if (!rst_n) preg[c] <= DEF;
         else if (clk_en[c]) begin
            if (periph_rst[c]) preg[c] <= DEF;
            else if (wr[c] && acc_en[c]) preg[c] <= wdata;
         end
      end
   end
   always_comb for (int c = 0; c < N; c++) rd_data_in[DW*c +: DW] = preg[c];

   function automatic bit f_clk(int s); return (s == 0) || (s == 2) || (s == 4); endfunction
   function automatic bit f_rst(int s); return (s >= 2); endfunction
   function automatic bit f_acc(int s); return (s == 0); endfunction
   function automatic bit f_settled(int s); return (s == 0) || (s == 1) || (s == 3); endfunction

   function automatic int f_next(int s, int cnt, logic [1:0] r);
      case (s)
         0: return (r == 2'b01) ? 1 : (r == 2'b10) ? 2 : 0;
         1: return (r == 2'b00) ? 0 : (r == 2'b10) ? 2 : 1;
         2: return (cnt == HOLD-1) ? 3 : 2;
         3: return (r == 2'b00) ? 4 : 3;
         default: return (cnt == PRE-1) ? 0 : 4;
      endcase
   endfunction

   always @(posedge clk) begin
      for (int c = 0; c < N; c++) begin
         if (!rst_n) begin
            m_st[c] = 0; m_cnt[c] = 0; m_ack[c] = 0; m_nr[c] = 0; m_err[c] = 0;
         end else begin
            int nx;
            nx = f_next(m_st[c], m_cnt[c], mode_req[2*c +: 2]);
            m_err[c] = acc_req[c] && !f_acc(m_st[c]);
            if (f_rst(m_st[c])) m_nr[c] = 1'b1;
            else if (f_acc(m_st[c]) && reinit_done[c]) m_nr[c] = 1'b0;
            m_ack[c] = (nx != m_st[c]) && f_settled(nx);
            m_cnt[c] = (nx != m_st[c]) ? 0 : m_cnt[c] + 1;
            m_st[c] = nx;
         end
      end
   end

   task automatic chk(input string tag, input int ch, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s ch%0d actual=%h expected=%h", tag, ch, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         for (int c = 0; c < N; c++) begin
            chk("R9 status", c, 32'(status[3*c +: 3]), 32'(m_st[c]));
            chk("R1 R3 clk_en", c, 32'(clk_en[c]), 32'(f_clk(m_st[c])));
            chk("R3 R4 periph_rst", c, 32'(periph_rst[c]), 32'(f_rst(m_st[c])));
            chk("R1 acc_en", c, 32'(acc_en[c]), 32'(f_acc(m_st[c])));
            chk("R7 mode_ack", c, 32'(mode_ack[c]), 32'(m_ack[c]));
            chk("R5 needs_reinit", c, 32'(needs_reinit[c]), 32'(m_nr[c]));
            chk("R5 xfer_en", c, 32'(xfer_en[c]), 32'(f_acc(m_st[c]) && !m_nr[c]));
            chk("R6 acc_err", c, 32'(acc_err[c]), 32'(m_err[c]));
            chk("R6 rd_data", c, 32'(rd_data_out[DW*c +: DW]),
                32'(f_acc(m_st[c]) ? preg[c] : '0));
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_mode(input int ch, input logic [1:0] m);
      mode_req[2*ch +: 2] = m;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0017));
      step(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      for (int c = 0; c < N; c++) begin
         chk("R10 status", c, 32'(status[3*c +: 3]), 0);
         chk("R10 clk_en/rst/acc", c, {29'd0, clk_en[c], periph_rst[c], acc_en[c]}, 32'b101);
         chk("R10 nr/ack", c, {30'd0, needs_reinit[c], mode_ack[c]}, 0);
      end
      chk_on = 1'b1;
      step(1);

      // random phase
      for (int t = 0; t < 3000; t++) begin
         for (int c = 0; c < N; c++) begin
            if ($urandom % 8 == 0) set_mode(c, 2'($urandom % 4));
            acc_req[c]     = ($urandom % 3 == 0);
            reinit_done[c] = ($urandom % 16 == 0);
            wr[c]          = ($urandom % 4 == 0);
         end
         wdata = 16'($urandom);
         step(1);
      end

      // directed corners
      acc_req = '0; reinit_done = '0; wr = '0;
      for (int c = 0; c < N; c++) set_mode(c, 2'b00);
      step(12);
      reinit_done = '1; step(1); reinit_done = '0;

      // R2 retention across idle on channel 0
      wdata = 16'hA5C3; wr[0] = 1'b1; step(1); wr[0] = 1'b0;
      set_mode(0, 2'b01); step(3);
      acc_req[0] = 1'b1; step(1); acc_req[0] = 1'b0;
      @(negedge clk);
      chk("R6 blocked error pulse", 0, 32'(acc_err[0]), 1);
      chk("R6 blocked read zero", 0, 32'(rd_data_out[DW-1:0]), 0);
      step(1);
      @(negedge clk);
      chk("R6 error single cycle", 0, 32'(acc_err[0]), 0);
      set_mode(0, 2'b00); step(2);
      @(negedge clk);
      chk("R2 retained value", 0, 32'(rd_data_out[DW-1:0]), 32'hA5C3);
      chk("R2 no reinit flag", 0, 32'(needs_reinit[0]), 0);

      // R8 channel 1 into reset while others stay active
      set_mode(1, 2'b10); step(HOLD + 3);
      @(negedge clk);
      chk("R8 ch1 gated reset", 1, 32'(status[5:3]), 3);
      chk("R8 ch0 unaffected", 0, {30'd0, clk_en[0], periph_rst[0]}, 32'b10);
      chk("R8 ch2 unaffected", 2, {30'd0, clk_en[2], periph_rst[2]}, 32'b10);
      // R7 idle request in reset is ignored
      set_mode(1, 2'b01); step(5);
      @(negedge clk);
      chk("R7 idle ignored in reset", 1, 32'(status[5:3]), 3);

      // R4 channel 0 through synchronized reset
      set_mode(0, 2'b10); step(HOLD + 3);
      set_mode(0, 2'b00); step(PRE + 3);
      @(negedge clk);
      chk("R4 default after reset", 0, 32'(rd_data_out[DW-1:0]), 32'(DEF));
      chk("R5 reinit pending", 0, {30'd0, needs_reinit[0], xfer_en[0]}, 32'b10);
      reinit_done[0] = 1'b1; step(1); reinit_done[0] = 1'b0;
      @(negedge clk);
      chk("R5 reinit cleared", 0, {30'd0, needs_reinit[0], xfer_en[0]}, 32'b01);

      // R7 reserved code holds state with no acknowledge
      set_mode(2, 2'b11);
      for (int k = 0; k < 5; k++) begin
         step(1);
         @(negedge clk);
         chk("R7 reserved code", 2, {28'd0, status[8:6], mode_ack[2]}, 32'b0000);
      end

      step(4);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule